// File: doc/BRIEF.md
# Immediate Operand Expander

This block turns the compact constant carried in an instruction word into a full-width operand. Its inputs are a 64-bit field of immediate bits, a size code that says how many of those bits are valid, an operand-type code (with a flag for when the instruction has no type field) and a shift control for compact shifted integers. From these it builds one scalar of up to 128 bits and replicates it across a destination vector.

For integer types the constant is sign-extended or cut to the operand width. For float types the small forms are widened exactly: an 8-bit field is read as a signed integer, a 16-bit field as half precision and a 32-bit field as single precision. A 64-bit field is read as double precision. Type and size pairs that cannot be expanded raise an illegal flag instead of producing a value. The result is registered, so it appears one clock after the request is accepted.

Top module: `immx_expander`

## Requirements
- R1: Integer types use opType codes 0, 1, 2, 3 and 4, meaning 8, 16, 32, 64 and 128 bits. The fieldSize codes 0, 1, 2 and 3 select the low 8, 16, 32 or 64 bits of immBits. A field narrower than the operand is sign-extended to the operand width.
- R2: When an integer field is wider than the operand, only the low operand-width bits are kept. No error is raised. scalarOut bits above the operand width read zero.
- R3: With opType 5 (single, in scalarOut[31:0]) or 6 (double, in scalarOut[63:0]) and fieldSize 0, the 8-bit field is a two's-complement integer. It is converted exactly to that precision, and zero gives +0.
- R4: With a float type and fieldSize 1, the field is half precision. It is widened exactly, including subnormals. Infinities keep their sign. A NaN keeps its 10-bit payload at the top of the target fraction.
- R5: With fieldSize 2, the field is single precision. For opType 5 it is passed through unchanged. For opType 6 it is widened exactly, including subnormals, infinities and NaN payloads.
- R6: With fieldSize 3 and opType 6, the field is passed through as double precision. With fieldSize 3 and opType 5, the illegal flag is raised.
- R7: When shiftMode is 1 with an integer type and fieldSize 1 or 2, the sign-extended field is shifted left by shiftAmt (0 to 63). The product is kept to 64 bits, then sign-extended or cut to the operand width.
- R8: When hasType is 0, opType is ignored and the operand is a 32-bit integer.
- R9: vecOut holds the low operand-size bytes of scalarOut, repeated in every lane of that size.
- R10: Each of the following raises illegal, with scalarOut and vecOut both zero: opType 7 (quad float); single with a 64-bit field; shiftMode with a float type; shiftMode with fieldSize 0 or 3.
- R11: Reset clears all outputs. A request with inValid high produces outValid high and the new results on the next clock. Without a request, outValid is low and the results hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| immBits | input | 64 | Immediate field bits, right-aligned |
| fieldSize | input | 2 | Field size: 0=8, 1=16, 2=32, 3=64 bits |
| hasType | input | 1 | opType is meaningful when 1 |
| opType | input | 3 | Operand type code |
| shiftMode | input | 1 | Shifted compact integer mode |
| shiftAmt | input | 6 | Left shift amount in shifted mode |
| outValid | output | 1 | Result valid, one cycle after request |
| illegal | output | 1 | Unsupported type and size combination |
| scalarOut | output | 128 | Expanded scalar, zero above operand width |
| vecOut | output | VEC_BYTES*8 | Scalar replicated across the vector |

## Verification
The scalar, the vector and the illegal flag are all due exactly one clock after the request edge, and all three share one register stage. The bench drives each request on a falling edge and compares every output on the next falling edge. That point is half a period after the capturing edge and before the next request is driven. A separate check drops the request to confirm that outValid falls and the results hold. Expected floats come from real arithmetic on the field's value. Expected integers come from multiply-and-mask arithmetic.

// File: rtl/immx_pkg.sv
package immx_pkg;

  localparam int SCALAR_W = 128;
  localparam int IMM_W    = 64;

  typedef enum logic [1:0] {
    SRC_INT8   = 2'd0,
    SRC_HALF   = 2'd1,
    SRC_SINGLE = 2'd2,
    SRC_DOUBLE = 2'd3
  } floatSrc_e;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_SPEC = 2'd2
  } floatCls_e;

  typedef struct packed {
    logic      illegal;
    logic      intPath;
    logic      shiftPath;
    logic      toDouble;
    floatSrc_e fsrc;
    logic [2:0] sizeLog;
  } immStrobes_t;

  // index of the highest set bit, zero when no bit is set
  function automatic logic [4:0] leadPos(input logic [22:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < 23; i++) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

  // shift so the leading one lands just above bit 51, return the bits below it
  function automatic logic [51:0] alignFrac(input logic [22:0] v, input logic [4:0] p);
    logic [74:0] w;
    w = 75'(v) << (7'd52 - {2'b00, p});
    return w[51:0];
  endfunction

endpackage

// File: rtl/immx_ctrl.sv
module immx_ctrl
  import immx_pkg::*;
(
  input  logic        hasType,
  input  logic [2:0]  opType,
  input  logic [1:0]  fieldSize,
  input  logic        shiftMode,
  output immStrobes_t strb
);

  logic [2:0] effType;
  logic       isFloat;

  always_comb begin
    effType = hasType ? opType : 3'd2;
    isFloat = (effType >= 3'd5);
    strb = '0;
    strb.fsrc      = floatSrc_e'(fieldSize);
    strb.intPath   = !isFloat;
    strb.shiftPath = shiftMode;
    strb.toDouble  = (effType == 3'd6);
    if (!isFloat)               strb.sizeLog = effType;
    else if (effType == 3'd5)   strb.sizeLog = 3'd2;
    else if (effType == 3'd6)   strb.sizeLog = 3'd3;
    else                        strb.sizeLog = 3'd4;
    strb.illegal = (effType == 3'd7)
                || (effType == 3'd5 && fieldSize == 2'd3)
                || (shiftMode && (isFloat || fieldSize == 2'd0 || fieldSize == 2'd3));
  end

endmodule

// File: rtl/immx_datapath.sv
module immx_datapath
  import immx_pkg::*;
#(
  parameter int VEC_BYTES = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inValid,
  input  immStrobes_t            strb,
  input  logic [IMM_W-1:0]       immBits,
  input  logic [1:0]             fieldSize,
  input  logic [5:0]             shiftAmt,
  output logic                   outValid,
  output logic                   illegal,
  output logic [SCALAR_W-1:0]    scalarOut,
  output logic [VEC_BYTES*8-1:0] vecOut
);

  localparam int VEC_W = VEC_BYTES * 8;

  logic [SCALAR_W-1:0] sextImm, intRaw, intMask, intVal, fltVal, scalarNext;
  logic [63:0]         shifted64;
  logic [VEC_W-1:0]    vecNext;
  logic [3:0]          laneMask;

  // integer path
  always_comb begin
    unique case (fieldSize)
      2'd0:    sextImm = {{120{immBits[7]}},  immBits[7:0]};
      2'd1:    sextImm = {{112{immBits[15]}}, immBits[15:0]};
      2'd2:    sextImm = {{96{immBits[31]}},  immBits[31:0]};
      default: sextImm = {{64{immBits[63]}},  immBits};
    endcase
    shifted64 = sextImm[63:0] << shiftAmt;
    intRaw = strb.shiftPath ? {{64{shifted64[63]}}, shifted64} : sextImm;
    if (strb.sizeLog >= 3'd4) intMask = '1;
    else intMask = (SCALAR_W'(1) << (8 << strb.sizeLog)) - SCALAR_W'(1);
    intVal = intRaw & intMask;
  end

  // float path: unpack to sign, class, unbiased exponent, aligned fraction
  logic               fSign;
  floatCls_e          fCls;
  logic signed [11:0] fExp;
  logic [51:0]        fFrac;
  logic [7:0]         mag;
  logic [4:0]         lead;
  logic [31:0]        sglBits;
  logic [63:0]        dblBits;

  always_comb begin
    fSign = 1'b0;
    fCls  = CLS_ZERO;
    fExp  = '0;
    fFrac = '0;
    mag   = '0;
    lead  = '0;
    unique case (strb.fsrc)
      SRC_INT8: begin
        fSign = immBits[7];
        mag   = immBits[7] ? (8'd0 - immBits[7:0]) : immBits[7:0];
        if (mag != 8'd0) begin
          lead  = leadPos(23'(mag));
          fCls  = CLS_NORM;
          fExp  = $signed({7'b0, lead});
          fFrac = alignFrac(23'(mag), lead);
        end
      end
      SRC_HALF: begin
        fSign = immBits[15];
        if (immBits[14:10] == 5'h1f) begin
          fCls  = CLS_SPEC;
          fFrac = {immBits[9:0], 42'b0};
        end else if (immBits[14:10] != 5'd0) begin
          fCls  = CLS_NORM;
          fExp  = $signed({7'b0, immBits[14:10]}) - 12'sd15;
          fFrac = {immBits[9:0], 42'b0};
        end else if (immBits[9:0] != 10'd0) begin
          lead  = leadPos(23'(immBits[9:0]));
          fCls  = CLS_NORM;
          fExp  = $signed({7'b0, lead}) - 12'sd24;
          fFrac = alignFrac(23'(immBits[9:0]), lead);
        end
      end
      SRC_SINGLE: begin
        fSign = immBits[31];
        if (immBits[30:23] == 8'hff) begin
          fCls  = CLS_SPEC;
          fFrac = {immBits[22:0], 29'b0};
        end else if (immBits[30:23] != 8'd0) begin
          fCls  = CLS_NORM;
          fExp  = $signed({4'b0, immBits[30:23]}) - 12'sd127;
          fFrac = {immBits[22:0], 29'b0};
        end else if (immBits[22:0] != 23'd0) begin
          lead  = leadPos(immBits[22:0]);
          fCls  = CLS_NORM;
          fExp  = $signed({7'b0, lead}) - 12'sd149;
          fFrac = alignFrac(immBits[22:0], lead);
        end
      end
      default: ;
    endcase

    unique case (fCls)
      CLS_NORM: begin
        sglBits = {fSign, 8'(fExp + 12'sd127),  fFrac[51:29]};
        dblBits = {fSign, 11'(fExp + 12'sd1023), fFrac};
      end
      CLS_SPEC: begin
        sglBits = {fSign, 8'hff,   fFrac[51:29]};
        dblBits = {fSign, 11'h7ff, fFrac};
      end
      default: begin
        sglBits = {fSign, 31'b0};
        dblBits = {fSign, 63'b0};
      end
    endcase

    if (strb.fsrc == SRC_DOUBLE)    fltVal = {64'b0, immBits};
    else if (strb.fsrc == SRC_SINGLE && !strb.toDouble) fltVal = {96'b0, immBits[31:0]};
    else if (strb.toDouble)         fltVal = {64'b0, dblBits};
    else                            fltVal = {96'b0, sglBits};

    if (strb.illegal)      scalarNext = '0;
    else if (strb.intPath) scalarNext = intVal;
    else                   scalarNext = fltVal;
    laneMask = 4'((5'd1 << strb.sizeLog) - 5'd1);
  end

  // byte lanes of the broadcast vector
  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_lane
    localparam logic [3:0] LANE_POS = 4'(b % 16);
    logic [3:0] srcByte;
    assign srcByte = LANE_POS & laneMask;
    assign vecNext[b*8 +: 8] = scalarNext[{srcByte, 3'b000} +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      illegal   <= 1'b0;
      scalarOut <= '0;
      vecOut    <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        illegal   <= strb.illegal;
        scalarOut <= scalarNext;
        vecOut    <= vecNext;
      end
    end
  end

endmodule

// File: rtl/immx_expander.sv
module immx_expander
  import immx_pkg::*;
#(
  parameter int VEC_BYTES = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inValid,
  input  logic [63:0]            immBits,
  input  logic [1:0]             fieldSize,
  input  logic                   hasType,
  input  logic [2:0]             opType,
  input  logic                   shiftMode,
  input  logic [5:0]             shiftAmt,
  output logic                   outValid,
  output logic                   illegal,
  output logic [127:0]           scalarOut,
  output logic [VEC_BYTES*8-1:0] vecOut
);

  immStrobes_t strb;

  immx_ctrl ctrl_i (
    .hasType  (hasType),
    .opType   (opType),
    .fieldSize(fieldSize),
    .shiftMode(shiftMode),
    .strb     (strb)
  );

  immx_datapath #(.VEC_BYTES(VEC_BYTES)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strb     (strb),
    .immBits  (immBits),
    .fieldSize(fieldSize),
    .shiftAmt (shiftAmt),
    .outValid (outValid),
    .illegal  (illegal),
    .scalarOut(scalarOut),
    .vecOut   (vecOut)
  );

endmodule

// File: rtl/immx_checker.sv
module immx_checker #(
  parameter int VEC_BYTES = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   inValid,
  input logic [63:0]            immBits,
  input logic [1:0]             fieldSize,
  input logic                   hasType,
  input logic [2:0]             opType,
  input logic                   shiftMode,
  input logic [5:0]             shiftAmt,
  input logic                   outValid,
  input logic                   illegal,
  input logic [127:0]           scalarOut,
  input logic [VEC_BYTES*8-1:0] vecOut
);

  p_valid_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    outValid == $past(inValid));

  p_illegal_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (scalarOut == '0 && vecOut == '0));

  p_quad_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && hasType && opType == 3'd7) |=> illegal);

  p_single_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && hasType && opType == 3'd5 && fieldSize == 2'd3) |=> illegal);

  p_float_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && hasType && opType == 3'd5) |=> (scalarOut[127:32] == '0));

  p_lane_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vecOut[7:0] == scalarOut[7:0]);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(scalarOut) && $stable(illegal)));

  logic unusedInputs;
  assign unusedInputs = ^{immBits, shiftMode, shiftAmt};

endmodule

bind immx_expander immx_checker #(.VEC_BYTES(VEC_BYTES)) chk_i (.*);

// File: tb/immx_expander_tb_top.sv
module immx_expander_tb_top;

  localparam int VB = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic [63:0]   immBits = '0;
  logic [1:0]    fieldSize = '0;
  logic          hasType = 1'b0;
  logic [2:0]    opType = '0;
  logic          shiftMode = 1'b0;
  logic [5:0]    shiftAmt = '0;
  logic          outValid, illegal;
  logic [127:0]  scalarOut;
  logic [VB*8-1:0] vecOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  immx_expander #(.VEC_BYTES(VB)) dut_i (.*);

  function automatic logic [127:0] expInt(logic [63:0] imm, int fsz, int sz, bit sh, int amt);
    logic [127:0] v;
    logic [63:0]  t;
    case (fsz)
      0: v = {{120{imm[7]}},  imm[7:0]};
      1: v = {{112{imm[15]}}, imm[15:0]};
      2: v = {{96{imm[31]}},  imm[31:0]};
      default: v = {{64{imm[63]}}, imm};
    endcase
    if (sh) begin
      t = v[63:0] * (64'd1 << amt);
      v = {{64{t[63]}}, t};
    end
    if (sz < 4) v = v & ((128'd1 << (8 * (1 << sz))) - 128'd1);
    return v;
  endfunction

  function automatic logic [31:0] dblToSgl(logic [63:0] d);
    if (d[62:0] == '0) return {d[63], 31'b0};
    return {d[63], 8'(int'(d[62:52]) - 896), d[51:29]};
  endfunction

  function automatic logic [63:0] halfToDbl(logic [15:0] h);
    int e = int'(h[14:10]);
    int f = int'(h[9:0]);
    real x;
    if (e == 31) return {h[15], 11'h7ff, h[9:0], 42'b0};
    if (e == 0 && f == 0) return {h[15], 63'b0};
    if (e == 0) x = real'(f) * (2.0 ** (-24.0));
    else        x = real'(1024 + f) * (2.0 ** real'(e - 25));
    if (h[15]) x = -x;
    return $realtobits(x);
  endfunction

  function automatic logic [31:0] halfToSgl(logic [15:0] h);
    if (h[14:10] == 5'h1f) return {h[15], 8'hff, h[9:0], 13'b0};
    return dblToSgl(halfToDbl(h));
  endfunction

  function automatic logic [63:0] sglToDbl(logic [31:0] s);
    int e = int'(s[30:23]);
    real x;
    if (e == 255) return {s[31], 11'h7ff, s[22:0], 29'b0};
    if (e == 0 && s[22:0] == 0) return {s[31], 63'b0};
    if (e == 0) x = real'(s[22:0]) * (2.0 ** (-149.0));
    else        x = real'(32'h800000 + 32'(s[22:0])) * (2.0 ** real'(e - 150));
    if (s[31]) x = -x;
    return $realtobits(x);
  endfunction

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive on a falling edge, compare on the next falling edge
  task automatic apply(string req, logic [63:0] imm, int fsz, bit ht, int ot,
                       bit sh, int amt, int sz, logic [127:0] expS, bit expIll);
    logic [VB*8-1:0] expV;
    int os;
    immBits = imm; fieldSize = 2'(fsz); hasType = ht; opType = 3'(ot);
    shiftMode = sh; shiftAmt = 6'(amt); inValid = 1'b1;
    @(negedge clk);
    os = 1 << sz;
    for (int i = 0; i < VB; i++) expV[i*8 +: 8] = expS[8*(i % os) +: 8];
    if (expIll) expV = '0;
    nChecks++;
    if (scalarOut !== expS || illegal !== expIll || vecOut !== expV || outValid !== 1'b1) begin
      nFails++;
      $display("FAIL %s: imm=%h fsz=%0d type=%0d/%0d sh=%0d amt=%0d got s=%h ill=%0d v=%h expected s=%h ill=%0d v=%h",
               req, imm, fsz, ht, ot, sh, amt, scalarOut, illegal, vecOut, expS, expIll, expV);
    end
  endtask

  initial begin : watchdog
    #(20 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    logic [63:0] pats [8];
    pats[0] = 64'h0; pats[1] = 64'h7f; pats[2] = 64'h80; pats[3] = 64'hffff_ffff_ffff_ffff;
    pats[4] = 64'h8000_0000_8000_8001; pats[5] = 64'h1234_5678_9abc_def0;
    pats[6] = 64'h7fff_ffff_7fff_7fff; pats[7] = 64'hfedc_ba98_0000_00a5;

    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset valid", 128'(outValid), 128'd0);
    check("R11 reset scalar", scalarOut, 128'd0);
    check("R11 reset vector", 128'(vecOut[127:0] | vecOut[255:128]), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 integer extension and truncation
    for (int p = 0; p < 8; p++)
      for (int f = 0; f < 4; f++)
        for (int t = 0; t < 5; t++)
          apply((f <= t) ? "R1" : "R2", pats[p], f, 1'b1, t, 1'b0, 0, t,
                expInt(pats[p], f, t, 1'b0, 0), 1'b0);

    // R8 missing type field means 32-bit integer
    for (int p = 0; p < 8; p++)
      apply("R8", pats[p], p % 4, 1'b0, 7 - (p % 3), 1'b0, 0, 2,
            expInt(pats[p], p % 4, 2, 1'b0, 0), 1'b0);

    // R7 shifted compact integers
    for (int a = 0; a < 64; a++)
      for (int f = 1; f < 3; f++) begin
        apply("R7", pats[4], f, 1'b1, 3, 1'b1, a, 3, expInt(pats[4], f, 3, 1'b1, a), 1'b0);
        apply("R7", pats[6], f, 1'b1, 4, 1'b1, a, 4, expInt(pats[6], f, 4, 1'b1, a), 1'b0);
        apply("R7", pats[7], f, 1'b1, 1, 1'b1, a, 1, expInt(pats[7], f, 1, 1'b1, a), 1'b0);
      end

    // R3 every 8-bit integer to both precisions
    for (int v = 0; v < 256; v++) begin
      logic [63:0] d;
      d = (v == 0) ? 64'd0 : $realtobits(real'($signed(8'(v))));
      apply("R3", 64'(v), 0, 1'b1, 6, 1'b0, 0, 3, {64'b0, d}, 1'b0);
      apply("R3", 64'(v), 0, 1'b1, 5, 1'b0, 0, 2, {96'b0, dblToSgl(d)}, 1'b0);
    end

    // R4 every half value to single, a stride of them to double
    for (int h = 0; h < 65536; h++)
      apply("R4", 64'(h), 1, 1'b1, 5, 1'b0, 0, 2, {96'b0, halfToSgl(16'(h))}, 1'b0);
    for (int h = 0; h < 65536; h += 3)
      apply("R4", 64'(h), 1, 1'b1, 6, 1'b0, 0, 3, {64'b0, halfToDbl(16'(h))}, 1'b0);

    // R5 single to double and single pass-through
    for (int e = 0; e < 256; e += 17)
      for (int k = 0; k < 23; k++)
        for (int s = 0; s < 2; s++) begin
          logic [31:0] sv;
          sv = {1'(s), 8'(e), 23'(1 << k) | 23'(k * 977)};
          apply("R5", 64'(sv), 2, 1'b1, 6, 1'b0, 0, 3, {64'b0, sglToDbl(sv)}, 1'b0);
          apply("R5", {32'hdead_beef, sv}, 2, 1'b1, 5, 1'b0, 0, 2, {96'b0, sv}, 1'b0);
        end
    apply("R5", 64'h8000_0000, 2, 1'b1, 6, 1'b0, 0, 3, {64'b0, 64'h8000_0000_0000_0000}, 1'b0);
    apply("R5", 64'h0000_0001, 2, 1'b1, 6, 1'b0, 0, 3, {64'b0, sglToDbl(32'h1)}, 1'b0);

    // R6 double field
    for (int p = 0; p < 8; p++) begin
      apply("R6", pats[p], 3, 1'b1, 6, 1'b0, 0, 3, {64'b0, pats[p]}, 1'b0);
      apply("R6", pats[p], 3, 1'b1, 5, 1'b0, 0, 2, 128'd0, 1'b1);
    end

    // R10 unsupported combinations
    for (int f = 0; f < 4; f++) apply("R10", pats[5], f, 1'b1, 7, 1'b0, 0, 4, 128'd0, 1'b1);
    apply("R10", pats[5], 1, 1'b1, 5, 1'b1, 4, 2, 128'd0, 1'b1);
    apply("R10", pats[5], 2, 1'b1, 6, 1'b1, 4, 3, 128'd0, 1'b1);
    apply("R10", pats[5], 0, 1'b1, 3, 1'b1, 4, 3, 128'd0, 1'b1);
    apply("R10", pats[5], 3, 1'b1, 3, 1'b1, 4, 3, 128'd0, 1'b1);
    apply("R9", pats[5], 2, 1'b1, 2, 1'b0, 0, 2, expInt(pats[5], 2, 2, 1'b0, 0), 1'b0);

    // R11 idle cycle: valid drops, results hold
    inValid = 1'b0; immBits = 64'h55; fieldSize = 2'd0; opType = 3'd0;
    @(negedge clk);
    check("R11 idle valid", 128'(outValid), 128'd0);
    check("R11 idle hold", scalarOut, expInt(pats[5], 2, 2, 1'b0, 0));

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule